// File: doc/BRIEF.md
# Configurable 32-bit Counter Channel with Control Pin

This block is a single counter channel. It counts either prescaled clock ticks (upward or downward) or edges on an external event pin (up or down, as a direction pin selects). A second external pin, the control pin, can reload the counter from a preload register, clear it, snapshot it into a latch register, or gate it. Gating serves pulse-width measurement: the pulse width is the captured count divided by the prescaled tick rate.

In single-run operation the counter halts when it reaches the compare value. A command write that resets or loads the counter arms it again. In free-running operation it carries on past the compare value and wraps modulo 2^32. Typical uses are a watchdog (a preloaded down-count toward zero), an event limit, pulse-width capture and position tracking.

There are two interrupt sources, compare match and control action. Each has a sticky status bit and an individual enable, and a master enable gates the shared interrupt line. Software reaches every setting through a small word-addressed write port and a combinational read port.

Top module: `ctr_channel`

## Requirements
- R1: After reset the count, latch and status registers read 0 and `irq` is low. The channel is disarmed, so the count stays 0 until a command write arms it.
- R2: In the timer modes the counter steps once per prescaler tick. A divisor of 0 or 1 gives a tick every clock. A divisor of N gives a tick every N clocks.
- R3: Each pin passes through two synchronizer flops. In event mode (input mode 2) every synchronized rising edge of `evt_in` steps the counter: up when `dir_in` is 1 and down when it is 0.
- R4: In single-run mode (mode bit 2 = 0), a step that makes the count equal the compare value sets status bit 0 and halts the counter. Writing command bit 0 clears the count to 0 and re-arms the counter.
- R5: In free-running mode (mode bit 2 = 1) the counter keeps stepping past the compare value. It wraps modulo 2^32, and every step that lands on the compare value sets status bit 0.
- R6: In timer-down mode (input mode 1), writing command bit 1 copies the preload value into the count. With compare 0, the counter then falls one per tick, halts at 0 and sets status bit 0.
- R7: A synchronized rising edge of `ctl_in` copies the preload value into the count when the control mode (mode bits 6:4) is 1. It clears the count when the control mode is 2. Either action sets status bit 1.
- R8: In control mode 3, a rising edge of `ctl_in` copies the count into the latch register and sets status bit 1. The count itself is left untouched.
- R9: In control mode 4 the counter counts only while a measurement is open. A command reset arms the measurement. The next rising edge of `ctl_in` opens it and the following falling edge closes it and sets status bit 1. For a timer-up count at divisor 0, the count equals the number of clocks `ctl_in` was high. Later edges are ignored until the next command reset.
- R10: When a control load or clear falls in the same cycle as a count step, the control action wins and the step is dropped. A latch in the same cycle as a step captures the value before the step.
- R11: `irq` is high only when enable bit 31 (master) is set and some status bit is set whose enable bit (0 for match, 1 for control) is set. Status bits stay set until a 1 is written to them. A new event in the same cycle as that write wins.
- R12: Register map, by word address: 0 mode (bits 1:0 input mode 0 up, 1 down, 2 event; bit 2 free-running; bits 6:4 control mode 0 none, 1 load, 2 clear, 3 latch, 4 gate); 1 preload; 2 compare; 3 count (read only); 4 latch (read only); 5 prescaler divisor (bits 15:0); 6 interrupt enable; 7 interrupt status; 8 command (write only, reads 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Read data for `addr` |
| evt_in | input | 1 | Asynchronous event pin |
| ctl_in | input | 1 | Asynchronous control pin |
| dir_in | input | 1 | Asynchronous count direction, 1 = up |
| irq | output | 1 | Interrupt request |

## Verification
A count step and a control action can land in the same clock cycle, because both pins pass through identical synchronizers. The bench provokes this by raising `evt_in` and `ctl_in` on the same falling clock edge, first in load mode and then in latch mode. In load mode the count must equal the preload value exactly, not the preload plus one. In latch mode the latch must hold the pre-step value while the count advances by one. A status event colliding with its own acknowledge write is guarded by an assertion that requires the bit to stay set.

// File: rtl/ctr_pkg.sv
// Package: shared encodings for the counter channel.
// Assumes a 32-bit data path and word-addressed registers.
package ctr_pkg;

    typedef enum logic [1:0] {
        IN_TIMER_UP = 2'd0,
        IN_TIMER_DN = 2'd1,
        IN_EVENT    = 2'd2
    } in_mode_e;

    typedef enum logic [2:0] {
        CM_NONE  = 3'd0,
        CM_LOAD  = 3'd1,
        CM_CLEAR = 3'd2,
        CM_LATCH = 3'd3,
        CM_GATE  = 3'd4
    } ctl_mode_e;

    typedef enum logic [1:0] {
        G_WAIT = 2'd0,
        G_MEAS = 2'd1,
        G_DONE = 2'd2
    } gate_state_e;

    localparam int A_MODE    = 0;
    localparam int A_PRELOAD = 1;
    localparam int A_COMPARE = 2;
    localparam int A_COUNT   = 3;
    localparam int A_LATCH   = 4;
    localparam int A_PSC     = 5;
    localparam int A_IRQ_EN  = 6;
    localparam int A_IRQ_ST  = 7;
    localparam int A_CMD     = 8;

    localparam int N_IRQ   = 2;
    localparam int IRQ_MATCH = 0;
    localparam int IRQ_CTL   = 1;

endpackage

// File: rtl/ctr_pin_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each pin toggles slower than the clock; no edge detection here.
module ctr_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync
);

    for (genvar s = 0; s < STAGES; s++) begin : g_st
        logic [WIDTH-1:0] q;
        if (s == 0) begin : g_first
            // First capture flop for the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= pin_async;
            end
        end else begin : g_next
            // Further resolution stage.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= g_st[s-1].q;
            end
        end
    end

    assign pin_sync = g_st[STAGES-1].q;

endmodule

// File: rtl/ctr_prescaler.sv
// Module: clock-enable divider producing one tick every DIV clocks.
// Assumes DIV of 0 or 1 means a tick on every clock.
module ctr_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             last;

    // Terminal phase of the divider; >= tolerates a shrinking divisor.
    assign last = (div <= DIV_W'(1)) || (cnt_q >= div - DIV_W'(1));
    assign tick = last;

    // Phase counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (last) cnt_q <= '0;
        else           cnt_q <= cnt_q + DIV_W'(1);
    end

    // R2: with a divisor above one, ticks never come back to back.
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div > DIV_W'(1)) |=> (!tick || !$stable(div)));

endmodule

// File: rtl/ctr_core.sv
// Module: counter datapath with step source selection, compare match,
// control-pin actions and gated measurement.
// Assumes pin levels are already synchronized; edges are found here.
module ctr_core
    import ctr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  in_mode_e         in_mode,
    input  logic             free_run,
    input  ctl_mode_e        ctl_mode,
    input  logic [CNT_W-1:0] preload,
    input  logic [CNT_W-1:0] compare,
    input  logic             tick,
    input  logic             evt_lvl,
    input  logic             ctl_lvl,
    input  logic             dir_lvl,
    input  logic             cmd_clear,
    input  logic             cmd_load,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] latch_val,
    output logic             match_evt,
    output logic             ctl_evt
);

    logic [CNT_W-1:0] count_q, latch_q, step_val;
    logic             run_q, evt_prev_q, ctl_prev_q;
    gate_state_e      gstate_q;
    logic             evt_rise, ctl_rise, ctl_fall;
    logic             count_down, src_pulse, gate_open, step;
    logic             ctl_overwrite, cmd_any, latch_hit, gate_done;

    assign evt_rise = evt_lvl & ~evt_prev_q;
    assign ctl_rise = ctl_lvl & ~ctl_prev_q;
    assign ctl_fall = ~ctl_lvl & ctl_prev_q;

    // Step source, direction and the actions that compete with a step.
    always_comb begin
        count_down    = (in_mode == IN_TIMER_DN) || ((in_mode == IN_EVENT) && !dir_lvl);
        src_pulse     = (in_mode == IN_EVENT) ? evt_rise : tick;
        gate_open     = (ctl_mode != CM_GATE) || (gstate_q == G_MEAS);
        step          = run_q && gate_open && src_pulse;
        step_val      = count_down ? count_q - CNT_W'(1) : count_q + CNT_W'(1);
        cmd_any       = cmd_clear || cmd_load;
        ctl_overwrite = ctl_rise && ((ctl_mode == CM_LOAD) || (ctl_mode == CM_CLEAR));
        latch_hit     = ctl_rise && (ctl_mode == CM_LATCH);
        gate_done     = (ctl_mode == CM_GATE) && (gstate_q == G_MEAS) && ctl_fall && !cmd_any;
        match_evt     = step && !cmd_any && !ctl_overwrite && (step_val == compare);
        ctl_evt       = (ctl_overwrite && !cmd_any) || latch_hit || gate_done;
    end

    // Edge history for the synchronized pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_prev_q <= 1'b0;
            ctl_prev_q <= 1'b0;
        end else begin
            evt_prev_q <= evt_lvl;
            ctl_prev_q <= ctl_lvl;
        end
    end

    // Counter value: command, then control action, then normal step.
    always_ff @(posedge clk) begin
        if (!rst_n)             count_q <= '0;
        else if (cmd_clear)     count_q <= '0;
        else if (cmd_load)      count_q <= preload;
        else if (ctl_overwrite) count_q <= (ctl_mode == CM_LOAD) ? preload : '0;
        else if (step)          count_q <= step_val;
    end

    // Arm flag: set by commands and control reloads, dropped on a single-run match.
    always_ff @(posedge clk) begin
        if (!rst_n)                         run_q <= 1'b0;
        else if (cmd_any || ctl_overwrite)  run_q <= 1'b1;
        else if (match_evt && !free_run)    run_q <= 1'b0;
    end

    // Gated measurement sequence: wait for rise, measure, done on fall.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_any) gstate_q <= G_WAIT;
        else if (ctl_mode == CM_GATE) begin
            if (gstate_q == G_WAIT && ctl_rise)      gstate_q <= G_MEAS;
            else if (gstate_q == G_MEAS && ctl_fall) gstate_q <= G_DONE;
        end
    end

    // Snapshot register for latch mode.
    always_ff @(posedge clk) begin
        if (!rst_n)         latch_q <= '0;
        else if (latch_hit) latch_q <= count_q;
    end

    assign count     = count_q;
    assign latch_val = latch_q;

    // R4: a disarmed counter holds unless a command or control reload arrives.
    p_disarmed_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !cmd_any && !ctl_overwrite) |=> $stable(count_q));

    // R4: a single-run match disarms the counter.
    p_single_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && !free_run && !cmd_any) |=> !run_q);

    // R9: before the gate opens the count does not move.
    p_gate_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_mode == CM_GATE && gstate_q == G_WAIT && !cmd_any) |=> $stable(count_q));

    // R7 / R10: a control load wins over any step in the same cycle.
    p_ctl_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rise && ctl_mode == CM_LOAD && !cmd_any) |=> (count_q == $past(preload)));

    // R8: the latch captures the count seen before the edge.
    p_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rise && ctl_mode == CM_LATCH) |=> (latch_q == $past(count_q)));

endmodule

// File: rtl/ctr_regs.sv
// Module: register file, command strobes, sticky status and interrupt line.
// Assumes single-cycle writes; reads are combinational and side-effect free.
module ctr_regs
    import ctr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PSC_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  latch_val,
    input  logic              match_evt,
    input  logic              ctl_evt,
    output in_mode_e          in_mode,
    output logic              free_run,
    output ctl_mode_e         ctl_mode,
    output logic [CNT_W-1:0]  preload,
    output logic [CNT_W-1:0]  compare,
    output logic [PSC_W-1:0]  psc_div,
    output logic              cmd_clear,
    output logic              cmd_load,
    output logic              irq
);

    localparam int MASTER_BIT = CNT_W - 1;

    in_mode_e         in_mode_q;
    ctl_mode_e        ctl_mode_q;
    logic             free_run_q;
    logic [CNT_W-1:0] preload_q, compare_q;
    logic [PSC_W-1:0] psc_q;
    logic [N_IRQ-1:0] en_q, stat_q, set_vec, ack_mask;
    logic             master_q;
    logic             wr_mode, wr_ack;

    function automatic in_mode_e dec_in(input logic [1:0] v);
        case (v)
            2'd1:    return IN_TIMER_DN;
            2'd2:    return IN_EVENT;
            default: return IN_TIMER_UP;
        endcase
    endfunction

    function automatic ctl_mode_e dec_ctl(input logic [2:0] v);
        case (v)
            3'd1:    return CM_LOAD;
            3'd2:    return CM_CLEAR;
            3'd3:    return CM_LATCH;
            3'd4:    return CM_GATE;
            default: return CM_NONE;
        endcase
    endfunction

    // Write decode and command strobes.
    always_comb begin
        wr_mode   = wr_en && (int'(addr) == A_MODE);
        wr_ack    = wr_en && (int'(addr) == A_IRQ_ST);
        cmd_clear = wr_en && (int'(addr) == A_CMD) && wdata[0];
        cmd_load  = wr_en && (int'(addr) == A_CMD) && wdata[1];
        ack_mask  = wr_ack ? wdata[N_IRQ-1:0] : '0;
        set_vec   = '0;
        set_vec[IRQ_MATCH] = match_evt;
        set_vec[IRQ_CTL]   = ctl_evt;
    end

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_mode_q  <= IN_TIMER_UP;
            ctl_mode_q <= CM_NONE;
            free_run_q <= 1'b0;
            preload_q  <= '0;
            compare_q  <= '0;
            psc_q      <= '0;
            en_q       <= '0;
            master_q   <= 1'b0;
        end else if (wr_en) begin
            if (wr_mode) begin
                in_mode_q  <= dec_in(wdata[1:0]);
                free_run_q <= wdata[2];
                ctl_mode_q <= dec_ctl(wdata[6:4]);
            end
            if (int'(addr) == A_PRELOAD) preload_q <= wdata;
            if (int'(addr) == A_COMPARE) compare_q <= wdata;
            if (int'(addr) == A_PSC)     psc_q     <= wdata[PSC_W-1:0];
            if (int'(addr) == A_IRQ_EN) begin
                en_q     <= wdata[N_IRQ-1:0];
                master_q <= wdata[MASTER_BIT];
            end
        end
    end

    // Sticky status: new events win over a simultaneous acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~ack_mask) | set_vec;
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (int'(addr))
            A_MODE: begin
                rdata[1:0] = in_mode_q;
                rdata[2]   = free_run_q;
                rdata[6:4] = ctl_mode_q;
            end
            A_PRELOAD: rdata = preload_q;
            A_COMPARE: rdata = compare_q;
            A_COUNT:   rdata = count;
            A_LATCH:   rdata = latch_val;
            A_PSC:     rdata[PSC_W-1:0] = psc_q;
            A_IRQ_EN: begin
                rdata[N_IRQ-1:0]  = en_q;
                rdata[MASTER_BIT] = master_q;
            end
            A_IRQ_ST:  rdata[N_IRQ-1:0] = stat_q;
            default:   rdata = '0;
        endcase
    end

    assign irq      = master_q && |(stat_q & en_q);
    assign in_mode  = in_mode_q;
    assign free_run = free_run_q;
    assign ctl_mode = ctl_mode_q;
    assign preload  = preload_q;
    assign compare  = compare_q;
    assign psc_div  = psc_q;

    for (genvar b = 0; b < N_IRQ; b++) begin : g_stat_chk
        // R11: a status bit stays set until acknowledged.
        p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[b] && !ack_mask[b]) |=> stat_q[b]);
        // R11: an acknowledge with no new event clears the bit.
        p_ack_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_mask[b] && !set_vec[b]) |=> !stat_q[b]);
        // R11: an event in the same cycle as its acknowledge survives.
        p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[b] |=> stat_q[b]);
    end

endmodule

// File: rtl/ctr_channel.sv
// Module: top of the counter channel; ties synchronizer, prescaler,
// counter core and registers together.
// Assumes evt_in, ctl_in and dir_in are asynchronous to clk.
module ctr_channel
    import ctr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PSC_W       = 16,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              evt_in,
    input  logic              ctl_in,
    input  logic              dir_in,
    output logic              irq
);

    localparam int N_PINS = 3;

    logic [N_PINS-1:0] pins_sync;
    in_mode_e          in_mode;
    ctl_mode_e         ctl_mode;
    logic              free_run, tick, cmd_clear, cmd_load, match_evt, ctl_evt;
    logic [CNT_W-1:0]  preload, compare, count, latch_val;
    logic [PSC_W-1:0]  psc_div;

    ctr_pin_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async ({dir_in, ctl_in, evt_in}),
        .pin_sync  (pins_sync)
    );

    ctr_prescaler #(.DIV_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (psc_div),
        .tick  (tick)
    );

    ctr_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_mode   (in_mode),
        .free_run  (free_run),
        .ctl_mode  (ctl_mode),
        .preload   (preload),
        .compare   (compare),
        .tick      (tick),
        .evt_lvl   (pins_sync[0]),
        .ctl_lvl   (pins_sync[1]),
        .dir_lvl   (pins_sync[2]),
        .cmd_clear (cmd_clear),
        .cmd_load  (cmd_load),
        .count     (count),
        .latch_val (latch_val),
        .match_evt (match_evt),
        .ctl_evt   (ctl_evt)
    );

    ctr_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .count     (count),
        .latch_val (latch_val),
        .match_evt (match_evt),
        .ctl_evt   (ctl_evt),
        .in_mode   (in_mode),
        .free_run  (free_run),
        .ctl_mode  (ctl_mode),
        .preload   (preload),
        .compare   (compare),
        .psc_div   (psc_div),
        .cmd_clear (cmd_clear),
        .cmd_load  (cmd_load),
        .irq       (irq)
    );

endmodule

// File: tb/sim_ctr_channel.sv
// Bench: event-count vector table walk, then directed mode and corner tests.
module sim_ctr_channel;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    localparam logic [3:0] R_MODE = 4'd0, R_PRE = 4'd1, R_CMP = 4'd2, R_CNT = 4'd3,
                           R_LAT = 4'd4, R_PSC = 4'd5, R_EN = 4'd6, R_ST = 4'd7,
                           R_CMD = 4'd8;

    // {dir, expected match status bit, expected count}; free-running, compare 2.
    localparam logic [33:0] VEC [8] = '{
        {1'b1, 1'b0, 32'h0000_0001},
        {1'b1, 1'b1, 32'h0000_0002},
        {1'b1, 1'b1, 32'h0000_0003},
        {1'b0, 1'b1, 32'h0000_0002},
        {1'b0, 1'b1, 32'h0000_0001},
        {1'b0, 1'b1, 32'h0000_0000},
        {1'b0, 1'b1, 32'hFFFF_FFFF},
        {1'b1, 1'b1, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        evt_in = 1'b0, ctl_in = 1'b0, dir_in = 1'b1;
    logic        irq;
    int          n_checks = 0;
    int          n_err = 0;
    logic [31:0] v;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctr_channel u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .evt_in(evt_in), .ctl_in(ctl_in), .dir_in(dir_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse_evt(input logic dir);
        @(negedge clk);
        dir_in = dir; evt_in = 1'b1;
        repeat (4) @(negedge clk);
        evt_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_ctl();
        @(negedge clk);
        ctl_in = 1'b1;
        repeat (4) @(negedge clk);
        ctl_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_both();
        @(negedge clk);
        dir_in = 1'b1; evt_in = 1'b1; ctl_in = 1'b1;
        repeat (4) @(negedge clk);
        evt_in = 1'b0; ctl_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and disarmed counter
        rd(R_CNT, v); chk("R1 count", v, 32'h0);
        rd(R_LAT, v); chk("R1 latch", v, 32'h0);
        rd(R_ST, v);  chk("R1 status", v, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        repeat (20) @(negedge clk);
        rd(R_CNT, v); chk("R1 disarmed count", v, 32'h0);

        // R3/R5 table: event counting, free-running, compare 2
        wr(R_MODE, 32'h6); wr(R_CMP, 32'd2); wr(R_CMD, 32'h1); wr(R_ST, 32'h3);
        rd(R_MODE, v); chk("R12 mode readback", v, 32'h6);
        for (int i = 0; i < 8; i++) begin
            pulse_evt(VEC[i][33]);
            rd(R_CNT, v); chk($sformatf("R3/R5 vec%0d count", i), v, VEC[i][31:0]);
            rd(R_ST, v);  chk($sformatf("R5 vec%0d match", i), {31'h0, v[0]}, {31'h0, VEC[i][32]});
        end

        // R4: single-run event limit stops and re-arms on command reset
        wr(R_MODE, 32'h2); wr(R_CMP, 32'd3); wr(R_CMD, 32'h1); wr(R_ST, 32'h3);
        repeat (3) pulse_evt(1'b1);
        rd(R_CNT, v); chk("R4 count at limit", v, 32'd3);
        rd(R_ST, v);  chk("R4 match status", v, 32'h1);
        pulse_evt(1'b1);
        rd(R_CNT, v); chk("R4 halted", v, 32'd3);
        wr(R_CMD, 32'h1);
        rd(R_CNT, v); chk("R4 cleared", v, 32'd0);
        pulse_evt(1'b1);
        rd(R_CNT, v); chk("R4 re-armed", v, 32'd1);

        // R2: prescaler divide by one and by three
        wr(R_MODE, 32'h0); wr(R_CMP, 32'hFFFF_0000); wr(R_PSC, 32'd0); wr(R_CMD, 32'h1);
        repeat (25) @(posedge clk);
        rd(R_CNT, v); chk("R2 div0 count", v, 32'd25);
        wr(R_PSC, 32'd3); wr(R_CMD, 32'h1);
        repeat (30) @(posedge clk);
        rd(R_CNT, v); chk("R2 div3 count", v, 32'd10);

        // R6: watchdog down-count from preload to zero
        wr(R_PSC, 32'd0); wr(R_PRE, 32'd40); wr(R_MODE, 32'h1); wr(R_CMD, 32'h2);
        wr(R_CMP, 32'd0); wr(R_ST, 32'h3); wr(R_CMD, 32'h2);
        repeat (20) @(posedge clk);
        rd(R_CNT, v); chk("R6 mid count", v, 32'd20);
        repeat (40) @(posedge clk);
        rd(R_CNT, v); chk("R6 halted at zero", v, 32'd0);
        rd(R_ST, v);  chk("R6 match status", v, 32'h1);

        // R7: control load and control clear
        wr(R_PRE, 32'd500); wr(R_MODE, 32'h16); wr(R_CMD, 32'h1); wr(R_ST, 32'h3);
        repeat (2) pulse_evt(1'b1);
        rd(R_CNT, v); chk("R7 pre-load count", v, 32'd2);
        pulse_ctl();
        rd(R_CNT, v); chk("R7 loaded", v, 32'd500);
        rd(R_ST, v);  chk("R7 load status", v, 32'h2);
        wr(R_MODE, 32'h26); wr(R_ST, 32'h3);
        pulse_ctl();
        rd(R_CNT, v); chk("R7 cleared", v, 32'd0);
        rd(R_ST, v);  chk("R7 clear status", v, 32'h2);

        // R8: latch snapshot leaves the count alone
        wr(R_MODE, 32'h36); wr(R_ST, 32'h3);
        repeat (3) pulse_evt(1'b1);
        pulse_ctl();
        rd(R_LAT, v); chk("R8 latch", v, 32'd3);
        rd(R_CNT, v); chk("R8 count kept", v, 32'd3);
        rd(R_ST, v);  chk("R8 status", v, 32'h2);

        // R10: step coinciding with control load, then with latch
        wr(R_MODE, 32'h16); wr(R_PRE, 32'd100); wr(R_CMD, 32'h1);
        repeat (5) pulse_evt(1'b1);
        rd(R_CNT, v); chk("R10 before", v, 32'd5);
        pulse_both();
        rd(R_CNT, v); chk("R10 load beats step", v, 32'd100);
        wr(R_MODE, 32'h36);
        pulse_both();
        rd(R_LAT, v); chk("R10 latch pre-step", v, 32'd100);
        rd(R_CNT, v); chk("R10 step after latch", v, 32'd101);

        // R9: gated pulse-width measurement
        wr(R_CMP, 32'hFFFF_0000); wr(R_MODE, 32'h40); wr(R_ST, 32'h3); wr(R_CMD, 32'h1);
        repeat (10) @(negedge clk);
        rd(R_CNT, v); chk("R9 waits for rise", v, 32'd0);
        @(negedge clk); ctl_in = 1'b1;
        repeat (50) @(negedge clk); ctl_in = 1'b0;
        repeat (10) @(negedge clk);
        rd(R_CNT, v); chk("R9 width", v, 32'd50);
        rd(R_ST, v);  chk("R9 done status", v, 32'h2);
        pulse_ctl();
        rd(R_CNT, v); chk("R9 ignores later edges", v, 32'd50);

        // R11: master enable, individual enables, acknowledge
        wr(R_MODE, 32'h36); wr(R_ST, 32'h3); wr(R_EN, 32'h3);
        pulse_ctl();
        rd(R_ST, v); chk("R11 status set", v, 32'h2);
        chk("R11 no master", {31'h0, irq}, 32'h0);
        wr(R_EN, 32'h8000_0003);
        @(negedge clk); chk("R11 master on", {31'h0, irq}, 32'h1);
        wr(R_EN, 32'h8000_0001);
        @(negedge clk); chk("R11 source masked", {31'h0, irq}, 32'h0);
        wr(R_EN, 32'h8000_0003); wr(R_ST, 32'h2);
        rd(R_ST, v); chk("R11 acknowledged", v, 32'h0);
        chk("R11 irq dropped", {31'h0, irq}, 32'h0);
        rd(R_CMD, v); chk("R12 command reads zero", v, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule